// File: doc/BRIEF.md
# Completion interrupt coalescer

This block sits beside a descriptor engine and decides when software should be told about finished work. It watches the number of descriptors that are completed but not yet released by software. It raises an interrupt message when that number reaches a programmed threshold. It also raises one when a programmable idle timer runs out while some completions are still outstanding. The message is a posted write of a programmed 32-bit data word to a programmed 48-bit address. It is offered on a valid/ready request port.

Software programs five things: the count threshold, a timeout enable, the timeout length, the two halves of the target address, and the data word. The engine supplies the live pending count and a one-cycle strobe for each new completion. Once a message has been raised, the block stays silent until the pending count moves. The count moves either through a new completion or through software releasing descriptors, so a single unhandled batch produces exactly one message.

Top module: `irq_coalescer`

## Requirements
- R1: After reset, `msg_valid` is 0.
- R2: When the block is armed and `pend_cnt` is nonzero and `pend_cnt >= cfg_thresh`, `msg_valid` is 1 after the next rising edge. `msg_addr` equals `{cfg_addr_hi[15:0], cfg_addr_lo}` and `msg_data` equals `cfg_data`, both taken at that edge.
- R3: No message is ever raised while `pend_cnt` is 0, whatever the threshold and timer settings.
- R4: With `cfg_tmo_en`=1 and 0 < `pend_cnt` < `cfg_thresh`, a message is raised at the (`cfg_tmo`+1)-th rising edge after the edge that sampled the last `done_strobe`, provided `pend_cnt` stays constant over that span.
- R5: With `cfg_tmo_en`=0, a pending count below the threshold never raises a message.
- R6: A `done_strobe` restarts the idle timer, so the timeout is measured from the most recent completion.
- R7: While `msg_valid`=1 and `msg_ready`=0, `msg_valid`, `msg_addr` and `msg_data` hold their values, even if the configuration inputs change. `msg_valid` is 0 after the edge at which `msg_valid` and `msg_ready` are both 1.
- R8: After a message has been raised, no further message is raised while `pend_cnt` is unchanged and no `done_strobe` arrives.
- R9: A change of `pend_cnt` in either direction, or a `done_strobe`, re-arms the block. If the threshold condition of R2 then holds, a new message appears after the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_cnt | input | 15 | Completed descriptors not yet released |
| done_strobe | input | 1 | One-cycle pulse per new completion |
| cfg_thresh | input | 15 | Count threshold |
| cfg_tmo_en | input | 1 | Enables the idle-timeout path |
| cfg_tmo | input | 13 | Idle-timeout length in cycles |
| cfg_addr_lo | input | 32 | Message address bits 31:0 |
| cfg_addr_hi | input | 32 | Only bits 15:0 are used, as address bits 47:32 |
| cfg_data | input | 32 | Message data word |
| msg_valid | output | 1 | Message request pending |
| msg_ready | input | 1 | Message accepted when high with msg_valid |
| msg_addr | output | 48 | Message address |
| msg_data | output | 32 | Message data word |

## Verification
The hardest situation to reach is the one where a message has already been accepted, the pending count still satisfies the threshold, and nothing has moved. Here the block must stay silent. It must then fire again at once when the count is nudged by one. The bench reaches this state by holding `msg_ready` low while checking that the request holds. It then accepts the request and idles with the count frozen. Only after that does it step the count, for every threshold and count pair in a small sweep. The timeout edge is located exactly for each of several short timeout values, including a restart partway through.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int CNT_W  = 15;
  localparam int TMO_W  = 13;
  localparam int LO_W   = 32;
  localparam int HI_W   = 16;
  localparam int ADDR_W = LO_W + HI_W;
  localparam int DATA_W = 32;

  // threshold path: a nonzero count at or above the limit
  function automatic logic count_reached(input int unsigned pend, input int unsigned thr);
    return (pend != 0) && (pend >= thr);
  endfunction

  // timeout path applies only to a nonzero count below the limit
  function automatic logic count_waiting(input int unsigned pend, input int unsigned thr);
    return (pend != 0) && (pend < thr);
  endfunction

  function automatic logic [ADDR_W-1:0] join_addr(input logic [LO_W-1:0] lo,
                                                  input logic [31:0] hi);
    return {hi[HI_W-1:0], lo};
  endfunction
endpackage

// File: rtl/irqc_arm_track.sv
module irqc_arm_track #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] pend_cnt,
  input  logic             done_strobe,
  input  logic             fire,
  output logic             arm_live,
  output logic             cnt_moved
);
  logic [CNT_W-1:0] pend_q;
  logic             armed_q;

  assign cnt_moved = (pend_cnt != pend_q) || done_strobe;
  assign arm_live  = armed_q || cnt_moved;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= '0;
      armed_q <= 1'b1;
    end else begin
      pend_q  <= pend_cnt;
      armed_q <= fire ? 1'b0 : arm_live;
    end
  end
endmodule

// File: rtl/irqc_idle_timer.sv
module irqc_idle_timer #(
  parameter int TMO_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);
  localparam logic [TMO_W-1:0] TMAX = '1;
  logic [TMO_W-1:0] tick_q;

  assign expired = run && !restart && (tick_q >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n)            tick_q <= '0;
    else if (restart)      tick_q <= '0;
    else if (run)          tick_q <= (tick_q == TMAX) ? TMAX : tick_q + 1'b1;
    else                   tick_q <= '0;
  end
endmodule

// File: rtl/irqc_msg_out.sv
module irqc_msg_out #(
  parameter int ADDR_W = 48,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic              ready,
  output logic              valid,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      addr  <= '0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      addr  <= addr_in;
      data  <= data_in;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_coalescer.sv
module irq_coalescer
  import irqc_pkg::*;
#(
  parameter int PCNT_W = CNT_W,
  parameter int TIME_W = TMO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PCNT_W-1:0] pend_cnt,
  input  logic              done_strobe,
  input  logic [PCNT_W-1:0] cfg_thresh,
  input  logic              cfg_tmo_en,
  input  logic [TIME_W-1:0] cfg_tmo,
  input  logic [LO_W-1:0]   cfg_addr_lo,
  input  logic [31:0]       cfg_addr_hi,
  input  logic [DATA_W-1:0] cfg_data,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [ADDR_W-1:0] msg_addr,
  output logic [DATA_W-1:0] msg_data
);
  logic arm_live, cnt_moved;
  logic thr_fire, tmo_fire, fire, tmr_run;

  assign thr_fire = arm_live && !msg_valid &&
                    count_reached(int'(unsigned'(pend_cnt)), int'(unsigned'(cfg_thresh)));
  assign tmr_run  = cfg_tmo_en && arm_live && !msg_valid &&
                    count_waiting(int'(unsigned'(pend_cnt)), int'(unsigned'(cfg_thresh)));
  assign fire     = thr_fire || tmo_fire;

  irqc_arm_track #(.CNT_W(PCNT_W)) arm_i (
    .clk(clk), .rst_n(rst_n), .pend_cnt(pend_cnt), .done_strobe(done_strobe),
    .fire(fire), .arm_live(arm_live), .cnt_moved(cnt_moved)
  );

  irqc_idle_timer #(.TMO_W(TIME_W)) tmr_i (
    .clk(clk), .rst_n(rst_n), .run(tmr_run), .restart(done_strobe),
    .limit(cfg_tmo), .expired(tmo_fire)
  );

  irqc_msg_out #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) out_i (
    .clk(clk), .rst_n(rst_n), .load(fire),
    .addr_in(join_addr(cfg_addr_lo, cfg_addr_hi)), .data_in(cfg_data),
    .ready(msg_ready), .valid(msg_valid), .addr(msg_addr), .data(msg_data)
  );
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int PCNT_W = 15,
  parameter int ADDR_W = 48,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PCNT_W-1:0] pend_cnt,
  input logic [PCNT_W-1:0] cfg_thresh,
  input logic              cfg_tmo_en,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [ADDR_W-1:0] msg_addr,
  input logic [DATA_W-1:0] msg_data,
  input logic              fire,
  input logic              tmo_fire
);
  // R7: request held while not accepted
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

  // R7: request drops after acceptance
  a_r7_drop: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_ready |=> !msg_valid);

  // R3: never raised on an empty count
  a_r3_no_empty: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> pend_cnt != '0);

  // R5: a below-threshold message needs the timeout path enabled
  a_r5_tmo_gate: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (pend_cnt < cfg_thresh) |-> cfg_tmo_en);

  // R4: the timer path only fires below threshold
  a_r4_tmo_below: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_fire |-> pend_cnt < cfg_thresh);
endmodule

bind irq_coalescer irqc_chk #(.PCNT_W(PCNT_W), .ADDR_W(irqc_pkg::ADDR_W), .DATA_W(irqc_pkg::DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .pend_cnt(pend_cnt), .cfg_thresh(cfg_thresh),
  .cfg_tmo_en(cfg_tmo_en), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_addr(msg_addr), .msg_data(msg_data), .fire(fire), .tmo_fire(tmo_fire)
);

// File: tb/irq_coalescer_tb_top.sv
module irq_coalescer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] pend_cnt = '0;
  logic        done_strobe = 1'b0;
  logic [14:0] cfg_thresh = 15'd4;
  logic        cfg_tmo_en = 1'b0;
  logic [12:0] cfg_tmo = '0;
  logic [31:0] cfg_addr_lo = 32'h89AB_CDEF;
  logic [31:0] cfg_addr_hi = 32'hDEAD_4567;
  logic [31:0] cfg_data = 32'h0000_1234;
  logic        msg_valid, msg_ready = 1'b0;
  logic [47:0] msg_addr;
  logic [31:0] msg_data;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  irq_coalescer dut_i (
    .clk(clk), .rst_n(rst_n), .pend_cnt(pend_cnt), .done_strobe(done_strobe),
    .cfg_thresh(cfg_thresh), .cfg_tmo_en(cfg_tmo_en), .cfg_tmo(cfg_tmo),
    .cfg_addr_lo(cfg_addr_lo), .cfg_addr_hi(cfg_addr_hi), .cfg_data(cfg_data),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pend_cnt = '0; done_strobe = 1'b0; msg_ready = 1'b0; cfg_tmo_en = 1'b0;
    step(2);
    rst_n = 1'b1;
  endtask

  task automatic pulse_strobe();
    done_strobe = 1'b1;
    step(1);
    done_strobe = 1'b0;
  endtask

  initial begin
    #900000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    check("R1 reset valid", 64'(msg_valid), 64'd0);

    // R2 R3 R7 R8 R9: threshold sweep
    for (int thr = 0; thr <= 4; thr++) begin
      for (int p = 0; p <= 5; p++) begin
        logic want;
        do_reset();
        cfg_thresh = 15'(thr);
        cfg_data = 32'(thr * 16 + p);
        pend_cnt = 15'(p);
        want = (p != 0) && (p >= thr);
        step(1);
        check(want ? "R2 threshold fire" : "R3 no fire", 64'(msg_valid), 64'(want));
        if (want) begin
          check("R2 addr", 64'(msg_addr), 64'h4567_89AB_CDEF);
          check("R2 data", 64'(msg_data), 64'(thr * 16 + p));
          cfg_data = 32'hFFFF_FFFF;
          step(3);
          check("R7 hold valid", 64'(msg_valid), 64'd1);
          check("R7 hold data", 64'(msg_data), 64'(thr * 16 + p));
          msg_ready = 1'b1;
          step(1);
          msg_ready = 1'b0;
          check("R7 drop", 64'(msg_valid), 64'd0);
          step(4);
          check("R8 silent", 64'(msg_valid), 64'd0);
          pend_cnt = 15'(p + 1);
          step(1);
          check("R9 rearm up", 64'(msg_valid), 64'd1);
          msg_ready = 1'b1;
          step(1);
          msg_ready = 1'b0;
          step(2);
          check("R8 silent again", 64'(msg_valid), 64'd0);
          pend_cnt = 15'(p);
          step(1);
          check("R9 rearm release", 64'(msg_valid), 64'd1);
        end else begin
          step(5);
          check("R3 R5 stays idle", 64'(msg_valid), 64'd0);
        end
      end
    end

    // R4: timeout edge for several lengths
    for (int t = 0; t <= 6; t++) begin
      do_reset();
      cfg_thresh = 15'd10; cfg_tmo_en = 1'b1; cfg_tmo = 13'(t);
      pend_cnt = 15'd3;
      pulse_strobe();
      if (t > 0) begin
        step(t);
        check("R4 not yet", 64'(msg_valid), 64'd0);
        step(1);
      end else begin
        step(1);
      end
      check("R4 timeout fire", 64'(msg_valid), 64'd1);
    end

    // R6: restart mid count
    do_reset();
    cfg_thresh = 15'd10; cfg_tmo_en = 1'b1; cfg_tmo = 13'd5;
    pend_cnt = 15'd2;
    pulse_strobe();
    step(3);
    pend_cnt = 15'd3;
    pulse_strobe();
    step(5);
    check("R6 restarted", 64'(msg_valid), 64'd0);
    step(1);
    check("R6 fires after restart", 64'(msg_valid), 64'd1);

    // R5: timeout disabled
    do_reset();
    cfg_thresh = 15'd10; cfg_tmo = 13'd2;
    pend_cnt = 15'd3;
    pulse_strobe();
    step(40);
    check("R5 disabled", 64'(msg_valid), 64'd0);

    // R3: empty count with timer on
    do_reset();
    cfg_thresh = 15'd10; cfg_tmo_en = 1'b1; cfg_tmo = 13'd1;
    pulse_strobe();
    step(20);
    check("R3 empty timer", 64'(msg_valid), 64'd0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule